// File: doc/BRIEF.md
# Link Ready-Line and Error Controller

This block manages the ready handshake between a host and the network node it is attached to. Software owns a local ready flop through a small register port. That flop drives the outgoing ready line. The node's incoming ready line is resynchronised to the local clock and shown to software as a status bit. It never raises an interrupt.

Two error flags record that the link may have lost state: one for the receive direction and one for the transmit direction. Each flag latches whenever the local ready flop or the synchronised node ready is low. Software clears each flag on its own. A clear loses to a set condition that is still present. The flags keep their value through reset.

An integrating stabilisation timer watches the local ready flop. The two per-bit handshake strobes, "next host bit available" and "ready for next node bit", pass only after local ready has stayed on for a programmed number of clock cycles, nominally half a second. Any drop of local ready restarts that interval. A restart from software therefore takes three steps: clear local ready, wait the interval, set local ready again.

Top module: `lrc_ready_ctrl`

## Requirements
- R1: Writing register address 0 loads bit 0 of the write data into the local ready flop; `host_ready_o` follows it from the next clock edge, reading address 0 returns it in bit 0 (other bits read 0), and it resets to 0.
- R2: Reading address 1 returns the node ready line in bit 0, after a two-flop synchroniser, so a change on `node_ready_i` appears after two clock edges.
- R3: The input error flag (address 1, bit 1) is set on the clock edge after the local ready flop or the synchronised node ready is low.
- R4: The output error flag (address 1, bit 2) is set under the same condition as the input error flag.
- R5: Writing address 1 with bit 1 set clears the input error flag, and with bit 2 set clears the output error flag; clearing one leaves the other untouched, and a zero in either bit has no effect.
- R6: If a clear arrives in the same cycle as a set condition, the flag stays set.
- R7: The error flags are not reset by `rst_n`; while reset is held they read as set.
- R8: Each low excursion of the node ready line lasting at least two clocks sets both error flags again, even after they have been cleared.
- R9: The stabilisation bit (address 1, bit 3) rises exactly STAB_CYCLES clock edges after local ready is set. It falls in the same cycle that local ready drops. Any drop restarts the full interval.
- R10: `host_bit_avail_o` and `node_bit_req_o` equal their input strobes ANDed with the stabilisation bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | AW | Register address for reads and writes (0 control, 1 status) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | DW | Register write data |
| reg_rd_data | output | DW | Register read data for `reg_addr` |
| node_ready_i | input | 1 | Ready line from the network node (asynchronous) |
| host_ready_o | output | 1 | Outgoing ready line driven by the local ready flop |
| host_bit_avail_i | input | 1 | Raw "next host bit available" strobe |
| node_bit_req_i | input | 1 | Raw "ready for next node bit" strobe |
| host_bit_avail_o | output | 1 | Gated "next host bit available" strobe |
| node_bit_req_o | output | 1 | Gated "ready for next node bit" strobe |

## Verification
The bench probes the stabilisation count one edge before and exactly at STAB_CYCLES, and again after a short on-off-on pulse of local ready. A timer that is off by one or that pauses instead of restarting would open the strobes early there. It clears a flag while the node line is still low in the synchroniser, where a design that lets the clear win would drop the flag. It also clears each flag alone, which exposes a shared or cross-wired clear. A bounce test checks that a second low excursion sets the flags again. A read taken while reset is held catches a design that resets the flags instead of keeping them.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  // register addresses
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  // control register fields
  localparam int unsigned CTRL_RDY_BIT = 0;
  // status register fields
  localparam int unsigned STAT_NODE_BIT = 0;
  localparam int unsigned STAT_ERR_IN_BIT = 1;
  localparam int unsigned STAT_ERR_OUT_BIT = 2;
  localparam int unsigned STAT_STABLE_BIT = 3;
  localparam int unsigned NUM_DIRS = 2;
endpackage

// File: rtl/lrc_sync2.sv
module lrc_sync2 #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], d_i};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= {2{RESET_VAL}};
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[1];
endmodule

// File: rtl/lrc_err_flag.sv
module lrc_err_flag (
  input  logic clk,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  // set has priority over clear; no reset so the flag survives it
  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/lrc_stab_timer.sv
module lrc_stab_timer #(
  parameter int unsigned CYCLES = 50_000_000,
  parameter bit          ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic stable_o
);
  localparam int unsigned LIMIT_INT = ENABLE ? CYCLES : 0;
  localparam int unsigned CW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LIMIT_INT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !arm_i || (cnt_q != LIMIT);
    cnt_d  = arm_i ? (cnt_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign stable_o = arm_i && (cnt_q == LIMIT);
endmodule

// File: rtl/lrc_ready_ctrl.sv
module lrc_ready_ctrl
  import lrc_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 2,
  parameter int unsigned STAB_CYCLES = 50_000_000,
  parameter bit          STAB_EN     = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr_en,
  input  logic [DW-1:0] reg_wr_data,
  output logic [DW-1:0] reg_rd_data,
  input  logic          node_ready_i,
  output logic          host_ready_o,
  input  logic          host_bit_avail_i,
  input  logic          node_bit_req_i,
  output logic          host_bit_avail_o,
  output logic          node_bit_req_o
);
  logic                rst_int_n;
  logic                node_rdy_s;
  logic                loc_rdy_q;
  logic                loc_rdy_d;
  logic                ctrl_wr;
  logic                stat_wr;
  logic                link_down;
  logic                stable;
  logic [NUM_DIRS-1:0] clr_vec;
  logic [NUM_DIRS-1:0] err_vec;
  logic                unused_wdata;

  // reset: asserted asynchronously, released on the clock
  lrc_sync2 #(.RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d_i(1'b1), .q_o(rst_int_n)
  );

  lrc_sync2 #(.RESET_VAL(1'b0)) u_node_sync (
    .clk(clk), .arst_n(rst_int_n), .d_i(node_ready_i), .q_o(node_rdy_s)
  );

  assign ctrl_wr = reg_wr_en && (reg_addr == AW'(ADDR_CTRL));
  assign stat_wr = reg_wr_en && (reg_addr == AW'(ADDR_STAT));

  always_comb begin
    loc_rdy_d = loc_rdy_q;
    if (ctrl_wr) loc_rdy_d = reg_wr_data[CTRL_RDY_BIT];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) loc_rdy_q <= 1'b0;
    else            loc_rdy_q <= loc_rdy_d;
  end

  assign host_ready_o = loc_rdy_q;
  assign link_down    = !loc_rdy_q || !node_rdy_s;

  assign clr_vec[0] = stat_wr && reg_wr_data[STAT_ERR_IN_BIT];
  assign clr_vec[1] = stat_wr && reg_wr_data[STAT_ERR_OUT_BIT];

  for (genvar g = 0; g < NUM_DIRS; g++) begin : g_err
    lrc_err_flag u_flag (
      .clk(clk), .set_i(link_down), .clr_i(clr_vec[g]), .flag_o(err_vec[g])
    );
  end

  lrc_stab_timer #(.CYCLES(STAB_CYCLES), .ENABLE(STAB_EN)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .arm_i(loc_rdy_q), .stable_o(stable)
  );

  assign host_bit_avail_o = host_bit_avail_i && stable;
  assign node_bit_req_o   = node_bit_req_i && stable;

  always_comb begin
    reg_rd_data = '0;
    if (reg_addr == AW'(ADDR_CTRL)) begin
      reg_rd_data[CTRL_RDY_BIT] = loc_rdy_q;
    end else if (reg_addr == AW'(ADDR_STAT)) begin
      reg_rd_data[STAT_NODE_BIT]    = node_rdy_s;
      reg_rd_data[STAT_ERR_IN_BIT]  = err_vec[0];
      reg_rd_data[STAT_ERR_OUT_BIT] = err_vec[1];
      reg_rd_data[STAT_STABLE_BIT]  = stable;
    end
  end

  assign unused_wdata = ^reg_wr_data[DW-1:3];
endmodule

// File: rtl/lrc_ready_ctrl_chk.sv
module lrc_ready_ctrl_chk
  import lrc_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 2,
  parameter bit          STAB_EN = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr_en,
  input logic [DW-1:0] reg_wr_data,
  input logic          host_ready_o,
  input logic          host_bit_avail_i,
  input logic          host_bit_avail_o,
  input logic          node_bit_req_o,
  input logic [1:0]    err_vec,
  input logic          stable
);
  logic ctrl_wr, clr_in, clr_out;
  assign ctrl_wr = reg_wr_en && (reg_addr == AW'(ADDR_CTRL));
  assign clr_in  = reg_wr_en && (reg_addr == AW'(ADDR_STAT)) && reg_wr_data[STAT_ERR_IN_BIT];
  assign clr_out = reg_wr_en && (reg_addr == AW'(ADDR_STAT)) && reg_wr_data[STAT_ERR_OUT_BIT];

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (host_ready_o == $past(reg_wr_data[CTRL_RDY_BIT]))); // R1
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(host_ready_o)); // R1
  AST_ERR_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready_o |=> err_vec[0]); // R3
  AST_ERR_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready_o |=> err_vec[1]); // R4
  AST_ERR_IN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec[0] && !clr_in) |=> err_vec[0]); // R5
  AST_ERR_OUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec[1] && !clr_out) |=> err_vec[1]); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_in && clr_out && !host_ready_o) |=> (err_vec[0] && err_vec[1])); // R6
  AST_NOT_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (STAB_EN && $rose(host_ready_o)) |-> !stable); // R9
  AST_GATE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_bit_avail_o || node_bit_req_o) |-> host_ready_o); // R10
  AST_GATE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    host_bit_avail_o |-> host_bit_avail_i); // R10
endmodule

bind lrc_ready_ctrl lrc_ready_ctrl_chk #(.DW(DW), .AW(AW), .STAB_EN(STAB_EN)) u_chk (
  .clk(clk),
  .rst_n(rst_int_n),
  .reg_addr(reg_addr),
  .reg_wr_en(reg_wr_en),
  .reg_wr_data(reg_wr_data),
  .host_ready_o(host_ready_o),
  .host_bit_avail_i(host_bit_avail_i),
  .host_bit_avail_o(host_bit_avail_o),
  .node_bit_req_o(node_bit_req_o),
  .err_vec(err_vec),
  .stable(stable)
);

// File: tb/lrc_ready_ctrl_tb.sv
module lrc_ready_ctrl_tb;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;
  localparam int unsigned N  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr_en = 1'b0;
  logic [DW-1:0] reg_wr_data = '0;
  logic [DW-1:0] reg_rd_data;
  logic          node_ready_i = 1'b1;
  logic          host_ready_o;
  logic          host_bit_avail_i = 1'b0;
  logic          node_bit_req_i = 1'b0;
  logic          host_bit_avail_o;
  logic          node_bit_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lrc_ready_ctrl #(.DW(DW), .AW(AW), .STAB_CYCLES(N), .STAB_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .node_ready_i(node_ready_i), .host_ready_o(host_ready_o),
    .host_bit_avail_i(host_bit_avail_i), .node_bit_req_i(node_bit_req_i),
    .host_bit_avail_o(host_bit_avail_o), .node_bit_req_o(node_bit_req_o)
  );

  typedef struct packed {
    logic          node;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata;
    logic [AW-1:0] raddr;
    logic [DW-1:0] exp;
  } vec_t;

  // each row: write, two idle edges, read raddr; status bit 3 masked
  localparam vec_t VECS [11] = '{
    '{1'b1, 2'd0, 8'h01, 2'd0, 8'h01}, // R1 set local ready
    '{1'b1, 2'd1, 8'h06, 2'd1, 8'h01}, // R5 clear both with link up
    '{1'b0, 2'd1, 8'h00, 2'd1, 8'h06}, // R2 R3 R4 node drop sets both
    '{1'b1, 2'd1, 8'h02, 2'd1, 8'h07}, // R6 clear lost to pending set
    '{1'b1, 2'd1, 8'h02, 2'd1, 8'h05}, // R5 input clear only
    '{1'b1, 2'd1, 8'h04, 2'd1, 8'h01}, // R5 output clear only
    '{1'b1, 2'd1, 8'h00, 2'd1, 8'h01}, // R5 zero write no effect
    '{1'b1, 2'd0, 8'h00, 2'd1, 8'h07}, // R3 R4 local ready drop
    '{1'b1, 2'd0, 8'hFF, 2'd0, 8'h01}, // R1 only bit 0 kept
    '{1'b1, 2'd1, 8'h06, 2'd1, 8'h01}, // R5 clear both again
    '{1'b1, 2'd2, 8'hFF, 2'd0, 8'h01}  // R1 unused address ignored
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = AW'(1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    reg_addr = AW'(0);
    #1 chk("R1 reset ctrl", reg_rd_data, 8'h00);
    chk("R1 reset line", {7'd0, host_ready_o}, 8'h00);
    reg_addr = AW'(1);
    #1 chk("R7 flags set in reset", reg_rd_data, 8'h06);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 synchroniser latency
    node_ready_i = 1'b0;
    @(negedge clk); chk("R2 after one edge", {7'd0, reg_rd_data[0]}, 8'h01);
    @(negedge clk); chk("R2 after two edges", {7'd0, reg_rd_data[0]}, 8'h00);
    node_ready_i = 1'b1;
    repeat (3) @(negedge clk);

    // R9 R10 stabilisation timing
    host_bit_avail_i = 1'b1; node_bit_req_i = 1'b1;
    reg_write(AW'(0), 8'h01);
    repeat (N - 1) @(negedge clk);
    chk("R9 not stable at N-1", {7'd0, reg_rd_data[3]}, 8'h00);
    chk("R10 strobes held", {6'd0, host_bit_avail_o, node_bit_req_o}, 8'h00);
    @(negedge clk);
    chk("R9 stable at N", {7'd0, reg_rd_data[3]}, 8'h01);
    chk("R10 strobes pass", {6'd0, host_bit_avail_o, node_bit_req_o}, 8'h03);
    reg_write(AW'(0), 8'h00);
    chk("R9 drop is immediate", {7'd0, reg_rd_data[3]}, 8'h00);
    chk("R10 strobes cut on drop", {6'd0, host_bit_avail_o, node_bit_req_o}, 8'h00);
    reg_write(AW'(0), 8'h01);
    repeat (N / 2) @(negedge clk);
    reg_write(AW'(0), 8'h00);
    reg_write(AW'(0), 8'h01);
    repeat (N - 1) @(negedge clk);
    chk("R9 restart after short pulse", {7'd0, reg_rd_data[3]}, 8'h00);
    @(negedge clk);
    chk("R9 stable after restart", {7'd0, reg_rd_data[3]}, 8'h01);
    host_bit_avail_i = 1'b0;
    #1 chk("R10 no strobe no pass", {6'd0, host_bit_avail_o, node_bit_req_o}, 8'h01);
    node_bit_req_i = 1'b0;
    reg_write(AW'(0), 8'h00);

    // vector table
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      node_ready_i = VECS[i].node;
      reg_addr = VECS[i].waddr; reg_wr_data = VECS[i].wdata; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = VECS[i].raddr;
      @(negedge clk);
      @(negedge clk);
      chk($sformatf("table row %0d", i), reg_rd_data & 8'h07, VECS[i].exp);
    end

    // R8 bounce: second low excursion sets flags again
    reg_addr = AW'(1);
    node_ready_i = 1'b0; repeat (2) @(negedge clk);
    node_ready_i = 1'b1; repeat (3) @(negedge clk);
    chk("R8 first bounce", reg_rd_data & 8'h07, 8'h07);
    reg_write(AW'(1), 8'h06);
    chk("R8 cleared between bounces", reg_rd_data & 8'h07, 8'h01);
    node_ready_i = 1'b0; repeat (2) @(negedge clk);
    node_ready_i = 1'b1; repeat (3) @(negedge clk);
    chk("R8 second bounce", reg_rd_data & 8'h07, 8'h07);
    reg_write(AW'(1), 8'h06);
    chk("R5 clear before reset", reg_rd_data & 8'h07, 8'h01);

    // R7 flags not wiped by reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1 chk("R7 flags during reset", reg_rd_data, 8'h06);
    reg_addr = AW'(0);
    #1 chk("R1 ctrl during reset", reg_rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_addr = AW'(1);
    #1 chk("R7 flags after reset", reg_rd_data & 8'h06, 8'h06);

    done = 1'b1;
    finish_run();
  end
endmodule